// File: doc/BRIEF.md
# Serial EEPROM Image Reader

This block copies the full contents of a small 3-wire serial EEPROM into an on-chip word array once a start request arrives. It drives the memory's select, clock and serial-input pins itself and shifts the returned bits in from the serial-output pin. For every word it issues a read command made of a start bit, a two-bit opcode and the word address. The words are fetched in ascending address order until the device has been read completely.

While the image streams in, the block adds all words with 16-bit wrap-around. At the end it compares the sum against a fixed signature and raises a checksum flag on a match. The first three words are also presented as a 48-bit station address. After completion, any stored word can be read back through a one-cycle-latency lookup port. A programmable divider sets the length of each serial half-period, so the pin timing can be matched to slow parts.

Top module: `romscan_top`

## Requirements
- R1: After reset, `ee_sk`, `ee_cs`, `ee_di`, `busy`, `done` and `csum_ok` are all low. The serial pins stay low whenever the block is idle.
- R2: A `start` pulse that arrives while idle makes `busy` and `ee_cs` high on the next clock edge.
- R3: Apart from the select edge that begins a run, a serial pin changes only at the end of a half-period. Every pin value is therefore held for at least `HALF_DIV` clock cycles.
- R4: For each word the block sends 9 command bits, most significant first, while `ee_cs` is high: a start bit 1, then opcode 2'b10, then the 6-bit word address. Each bit is valid on `ee_di` at the rising edge of `ee_sk`. Words are addressed 0 to 63 in increasing order.
- R5: Within one select period, the device presents data bit 15-k after the (10+k)-th rising edge of `ee_sk`, for k = 0..15. The block samples `ee_do` at the end of each high half. The assembled word is stored and returned on `rd_word` one cycle after its index is placed on `rd_idx`.
- R6: After the last data bit of a word, `ee_cs` and `ee_di` drop together. Exactly one `ee_sk` pulse is then issued with `ee_cs` low before the next word is selected, and after the final word.
- R7: When a run ends, `csum_ok` is high exactly when the 16-bit wrap-around sum of all 64 words equals 0xBABA. Accepting a new start clears it.
- R8: At completion, `station_addr` equals {word2, word1, word0}. Byte i sits in bits 8i+7..8i, and the low byte of each word is the earlier byte.
- R9: `done` is high for exactly one cycle after the last word. `busy` is already low in that cycle, and `csum_ok` and `station_addr` are valid in it.
- R10: A `start` that arrives while `busy` is high is ignored. The run still reads exactly 64 words in order and produces a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to read the whole device |
| ee_do | input | 1 | Serial data from the EEPROM |
| rd_idx | input | 6 | Word index for the lookup port |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_di | output | 1 | Serial data to the EEPROM |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| csum_ok | output | 1 | Word sum matched the signature |
| station_addr | output | 48 | Station address taken from words 0 to 2 |
| rd_word | output | 16 | Stored word at `rd_idx` (one-cycle latency) |

## Verification
A wrong slot or word counter shows up at the pins within one word, about 53 half-periods. It appears as a malformed command frame, a wrong address, or a tail with zero or two clock pulses. A shift or sampling error corrupts specific stored words. Those only become visible after `done`, through the lookup sweep, the station address and the checksum flag. A bad hold counter shows up as a pin interval shorter than `HALF_DIV` on the first change.

// File: rtl/romscan_pkg.sv
package romscan_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEL,
    PH_LO,
    PH_HI,
    PH_TL,
    PH_TH
  } phase_t;

  localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/romscan_tick.sv
module romscan_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/romscan_seq.sv
module romscan_seq
  import romscan_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              ee_do_i,
  output logic              ee_sk_o,
  output logic              ee_cs_o,
  output logic              ee_di_o,
  output logic              busy_o,
  output logic              clr_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              fin_o
);
  localparam int FRAME_W = 3 + ADDR_W;
  localparam int SLOTS   = FRAME_W + DATA_W;
  localparam int SW      = $clog2(SLOTS + 1);
  localparam logic [ADDR_W-1:0] LAST_WORD = '1;
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);
  localparam logic [SW-1:0] FIRST_DATA = SW'(FRAME_W);

  phase_t            phase_q;
  logic [SW-1:0]     slot_q;
  logic [ADDR_W-1:0] word_q;
  logic [DATA_W-1:0] shreg_q;
  logic [FRAME_W-1:0] frame;
  logic [SW-1:0]     slot_nx;
  logic              di_nx;

  assign frame   = {1'b1, OP_READ, word_q};
  assign slot_nx = (phase_q == PH_SEL) ? '0 : slot_q + 1'b1;

  always_comb begin
    di_nx = 1'b0;
    for (int i = 0; i < FRAME_W; i++) begin
      if (slot_nx == SW'(i)) di_nx = frame[FRAME_W-1-i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      slot_q    <= '0;
      word_q    <= '0;
      shreg_q   <= '0;
      ee_sk_o   <= 1'b0;
      ee_cs_o   <= 1'b0;
      ee_di_o   <= 1'b0;
      clr_o     <= 1'b0;
      wr_o      <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
      fin_o     <= 1'b0;
    end else begin
      clr_o <= 1'b0;
      wr_o  <= 1'b0;
      fin_o <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start_i) begin
          phase_q <= PH_SEL;
          word_q  <= '0;
          ee_cs_o <= 1'b1;
          ee_sk_o <= 1'b0;
          ee_di_o <= 1'b0;
          clr_o   <= 1'b1;
        end
      end else if (tick_i) begin
        case (phase_q)
          PH_SEL: begin
            phase_q <= PH_LO;
            slot_q  <= slot_nx;
            ee_di_o <= di_nx;
          end
          PH_LO: begin
            phase_q <= PH_HI;
            ee_sk_o <= 1'b1;
          end
          PH_HI: begin
            ee_sk_o <= 1'b0;
            if (slot_q >= FIRST_DATA) shreg_q <= {shreg_q[DATA_W-2:0], ee_do_i};
            if (slot_q == LAST_SLOT) begin
              phase_q   <= PH_TL;
              ee_cs_o   <= 1'b0;
              ee_di_o   <= 1'b0;
              wr_o      <= 1'b1;
              wr_idx_o  <= word_q;
              wr_data_o <= {shreg_q[DATA_W-2:0], ee_do_i};
            end else begin
              phase_q <= PH_LO;
              slot_q  <= slot_nx;
              ee_di_o <= di_nx;
            end
          end
          PH_TL: begin
            phase_q <= PH_TH;
            ee_sk_o <= 1'b1;
          end
          PH_TH: begin
            ee_sk_o <= 1'b0;
            if (word_q == LAST_WORD) begin
              phase_q <= PH_IDLE;
              fin_o   <= 1'b1;
            end else begin
              word_q  <= word_q + 1'b1;
              phase_q <= PH_SEL;
              ee_cs_o <= 1'b1;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (phase_q != PH_IDLE);

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    ({ee_sk_o, ee_cs_o, ee_di_o} != $past({ee_sk_o, ee_cs_o, ee_di_o}))
      |-> ($past(tick_i) || $past(phase_q) == PH_IDLE)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) |-> (!ee_sk_o && !ee_cs_o && !ee_di_o)); // R1

  AST_WORD_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    ((phase_q != PH_IDLE) && ($past(phase_q) != PH_IDLE)) |-> (word_q >= $past(word_q))); // R10

  AST_CS_DROP_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> (!ee_cs_o && !ee_di_o)); // R6
endmodule

// File: rtl/romscan_store.sv
module romscan_store #(
  parameter int ADDR_W        = 6,
  parameter int DATA_W        = 16,
  parameter int STATION_WORDS = 3,
  parameter logic [DATA_W-1:0] SIGNATURE = 16'hBABA
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clr_i,
  input  logic                            wr_i,
  input  logic [ADDR_W-1:0]               wr_idx_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  input  logic                            fin_i,
  input  logic [ADDR_W-1:0]               rd_idx_i,
  output logic [DATA_W-1:0]               rd_word_o,
  output logic                            csum_ok_o,
  output logic [STATION_WORDS*DATA_W-1:0] station_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] acc_q;
  logic [STATION_WORDS*DATA_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (wr_i) mem[wr_idx_i] <= wr_data_i;
    rd_word_o <= mem[rd_idx_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      csum_ok_o <= 1'b0;
      station_o <= '0;
    end else begin
      if (clr_i) begin
        acc_q     <= '0;
        csum_ok_o <= 1'b0;
      end else if (wr_i) begin
        acc_q <= acc_q + wr_data_i;
      end
      if (fin_i) begin
        csum_ok_o <= (acc_q == SIGNATURE);
        station_o <= stage_q;
      end
    end
  end

  for (genvar g = 0; g < STATION_WORDS; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[g*DATA_W +: DATA_W] <= '0;
      end else if (wr_i && (wr_idx_i == ADDR_W'(g))) begin
        stage_q[g*DATA_W +: DATA_W] <= wr_data_i;
      end
    end
  end

  AST_CSUM_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !csum_ok_o); // R7
endmodule

// File: rtl/romscan_top.sv
module romscan_top #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int HALF_DIV = 4,
  parameter logic [DATA_W-1:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ee_do,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic              ee_sk,
  output logic              ee_cs,
  output logic              ee_di,
  output logic              busy,
  output logic              done,
  output logic              csum_ok,
  output logic [3*DATA_W-1:0] station_addr,
  output logic [DATA_W-1:0] rd_word
);
  logic              tick;
  logic              clr;
  logic              wr;
  logic [ADDR_W-1:0] wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic              fin;

  romscan_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .run_i  (busy),
    .tick_o (tick)
  );

  romscan_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .tick_i    (tick),
    .ee_do_i   (ee_do),
    .ee_sk_o   (ee_sk),
    .ee_cs_o   (ee_cs),
    .ee_di_o   (ee_di),
    .busy_o    (busy),
    .clr_o     (clr),
    .wr_o      (wr),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data),
    .fin_o     (fin)
  );

  romscan_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATION_WORDS(3), .SIGNATURE(SIGNATURE)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr),
    .wr_i      (wr),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .fin_i     (fin),
    .rd_idx_i  (rd_idx),
    .rd_word_o (rd_word),
    .csum_ok_o (csum_ok),
    .station_o (station_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= fin;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
endmodule

// File: tb/romscan_top_tb.sv
module romscan_top_tb_top;
  localparam int CLK_P = 10;
  localparam int HALF  = 2;
  localparam logic [15:0] SIG = 16'hBABA;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        ee_do = 1'b0;
  logic [5:0]  rd_idx = '0;
  logic        ee_sk, ee_cs, ee_di, busy, done, csum_ok;
  logic [47:0] station_addr;
  logic [15:0] rd_word;

  int vectors = 0;
  int miscomp = 0;

  logic [15:0] image [64];

  int  edge_cnt, words_seen, frame_err, tail_cnt, tail_err, hold_err, run_len, done_cnt;
  logic [8:0] frame;
  logic [5:0] cur_addr;
  logic p_sk, p_cs, p_di, p_busy;

  always #(CLK_P/2) clk = ~clk;

  romscan_top #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst(rst), .start(start), .ee_do(ee_do), .rd_idx(rd_idx),
    .ee_sk(ee_sk), .ee_cs(ee_cs), .ee_di(ee_di), .busy(busy), .done(done),
    .csum_ok(csum_ok), .station_addr(station_addr), .rd_word(rd_word)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // EEPROM model and pin monitor, sampled away from the active edge
  initial begin
    p_sk = 0; p_cs = 0; p_di = 0; p_busy = 0; run_len = 1000;
    edge_cnt = 0; words_seen = 0; frame_err = 0; tail_cnt = 0; tail_err = 0;
    hold_err = 0; done_cnt = 0; frame = '0; cur_addr = '0;
    forever begin
      @(negedge clk);
      if (busy && !p_busy) begin
        words_seen = 0; frame_err = 0; tail_cnt = 0; tail_err = 0;
        hold_err = 0; done_cnt = 0;
      end
      if (done) done_cnt++;
      if ({ee_sk, ee_cs, ee_di} != {p_sk, p_cs, p_di}) begin
        if (run_len < HALF) hold_err++;
        run_len = 1;
      end else if (run_len < 1000) begin
        run_len++;
      end
      if (ee_cs && !p_cs) begin
        if (words_seen > 0 && tail_cnt != 1) tail_err++;
        edge_cnt = 0; tail_cnt = 0;
      end
      if (!ee_cs && p_cs && ee_di) frame_err++;
      if (ee_sk && !p_sk) begin
        if (ee_cs) begin
          edge_cnt++;
          if (edge_cnt <= 9) frame = {frame[7:0], ee_di};
          if (edge_cnt == 9) begin
            cur_addr = frame[5:0];
            if (frame[8] != 1'b1 || frame[7:6] != 2'b10 || frame[5:0] != 6'(words_seen))
              frame_err++;
            words_seen++;
          end
          if (edge_cnt >= 10 && edge_cnt <= 25) ee_do = image[cur_addr][25 - edge_cnt];
        end else begin
          tail_cnt++;
        end
      end
      p_sk = ee_sk; p_cs = ee_cs; p_di = ee_di; p_busy = busy;
    end
  end

  task automatic run_pass(input int p, input bit corrupt, input bit poke);
    logic [15:0] sum;
    int wait_cnt;
    sum = '0;
    for (int i = 0; i < 63; i++) begin
      image[i] = 16'(i * 16'h2F1D + p * 16'h1111 + 16'h005A) ^ 16'(p << (i % 7));
      sum = sum + image[i];
    end
    image[63] = SIG - sum + (corrupt ? 16'h0001 : 16'h0000);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy && ee_cs, "R2 busy and select after start", {busy, ee_cs}, 2'b11);
    if (poke) begin
      repeat (700) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (2500) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    wait_cnt = 0;
    while (!done && wait_cnt < 40000) begin
      @(negedge clk); wait_cnt++;
    end
    check(done, "R9 done seen", done, 1);
    check(!busy, "R9 busy low with done", busy, 0);
    check(csum_ok == !corrupt, "R7 checksum flag", csum_ok, !corrupt);
    check(station_addr == {image[2], image[1], image[0]}, "R8 station address",
          station_addr, {image[2], image[1], image[0]});
    check(station_addr[7:0] == image[0][7:0] && station_addr[15:8] == image[0][15:8],
          "R8 first two bytes", station_addr[15:0], image[0]);
    @(negedge clk);
    check(!done, "R9 done lasts one cycle", done, 0);
    for (int i = 0; i < 64; i++) begin
      rd_idx = 6'(i);
      @(negedge clk);
      check(rd_word == image[i], $sformatf("R5 stored word %0d", i), rd_word, image[i]);
    end
    check(words_seen == 64, "R10 word count", words_seen, 64);
    check(done_cnt == 1, "R10 single done", done_cnt, 1);
    check(frame_err == 0, "R4 command frames", frame_err, 0);
    check(tail_err == 0 && tail_cnt == 1, "R6 tail clock pulse", {tail_err, tail_cnt}, 1);
    check(hold_err == 0, "R3 pin hold time", hold_err, 0);
    check(!ee_sk && !ee_cs && !ee_di, "R1 pins idle after run", {ee_sk, ee_cs, ee_di}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!ee_sk && !ee_cs && !ee_di, "R1 pins after reset", {ee_sk, ee_cs, ee_di}, 0);
    check(!busy && !done && !csum_ok, "R1 status after reset", {busy, done, csum_ok}, 0);
    run_pass(0, 1'b0, 1'b0);
    run_pass(1, 1'b0, 1'b1);
    run_pass(2, 1'b1, 1'b0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!csum_ok, "R7 flag cleared by new start", csum_ok, 0);
    run_pass(3, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule